// File: doc/BRIEF.md
# Loop-back clock capture bridge

The block divides the core clock down to a slow interface clock, which leaves the chip on a clock-out pin. An external distribution buffer sends that clock to the attached device. It also returns a copy over a trace of matched length, as a loop-back clock. The device's read data is sampled on the rising edge of the returned copy. The returned copy has no fixed phase relation to the core clock, because the trace length is unknown.

The bridge does not synchronise the returned clock. It moves the captured word into the core domain on a schedule set entirely by the divider: a fixed number of core cycles after each rising edge of the clock-out signal. The core therefore sees every read word in the same cycle, whatever the trace delay, provided that delay is shorter than the transfer offset. The core needs no handshake and no flops for metastability, and read latency stays deterministic.

With the defaults (divide by 6, offset of 3), a 200 MHz core gives a 33 MHz interface and a transfer about 15 ns after the clock edge.

Top module: `lbk_bridge`

## Requirements
- R1: While `rst_n` is low, `ifc_clk_out`, `core_valid` and `core_data` are all 0. Reset is asynchronous and takes effect without a core clock edge.
- R2: After reset is released, `ifc_clk_out` rises on the first core clock edge. It then repeats with a period of DIV core cycles: high for DIV/2 cycles, then low for DIV/2 cycles.
- R3: The word on `lb_data` is captured on each rising edge of `lb_clk`.
- R4: `core_valid` is a single-cycle pulse. It goes high on the LAT-th core clock edge after each rising edge of `ifc_clk_out`, and at no other time.
- R5: `core_data` changes only on the edge that raises `core_valid`, and holds its value in every other cycle. It is 0 until the first transfer.
- R6: The cycle in which `core_valid` rises, and the value of `core_data`, do not depend on the `lb_clk` delay for any delay below LAT core cycles minus the capture setup.
- R7: The word transferred with a `core_valid` pulse is the word captured on the `lb_clk` rising edge that belongs to the most recent `ifc_clk_out` rising edge.
- R8: Asserting reset in the middle of a run clears the divider. After release, the clock-out phase and the transfer schedule restart exactly as they do after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lb_clk | input | 1 | Interface clock returned over the matched trace |
| lb_data | input | W | Read data from the device, valid around each `lb_clk` rising edge |
| ifc_clk_out | output | 1 | Divided interface clock, driven off-chip |
| core_data | output | W | Transferred word in the core domain |
| core_valid | output | 1 | One-cycle strobe marking a new `core_data` word |

## Verification
On every core cycle, the bound checker measures how old the current clock-out period is, counting from its own view of each clock-out rising edge. Against that count it holds the duty cycle and the period of the clock-out signal, the exact transfer offset of the strobe, the one-cycle width of the strobe, and the rule that data holds between strobes. Delay independence and correct capture only show up in the bench's scenarios. The bench sweeps the loop-back delay across the permitted window, drives a distinct word pattern in each interface period, and compares every core cycle against one schedule computed from the reset release. It also resets in the middle of a run, at a point away from any clock edge.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
    // Default configuration: 200 MHz core / 6 = 33 MHz interface clock,
    // handoff three core cycles after the clock-out rising edge.
    parameter int unsigned LBK_DIV_DEF = 6;
    parameter int unsigned LBK_LAT_DEF = 3;
    parameter int unsigned LBK_W_DEF   = 8;

    function automatic int unsigned lbk_cnt_width(int unsigned div);
        return (div > 1) ? $clog2(div) : 1;
    endfunction
endpackage

// File: rtl/lbk_clkdiv.sv
module lbk_clkdiv #(
    parameter int unsigned DIV = 6,
    parameter int unsigned CW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] phase,
    output logic          clk_o
);
    localparam int unsigned HALF = DIV / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          clk_o;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cnt   = (st_q.cnt == CW'(DIV - 1)) ? '0 : st_q.cnt + 1'b1;
        st_d.clk_o = (st_d.cnt < CW'(HALF));
    end

    // Reset parks the counter on its last phase so the first edge starts a period.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: CW'(DIV - 1), clk_o: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.cnt;
    assign clk_o = st_q.clk_o;
endmodule

// File: rtl/lbk_capture.sv
module lbk_capture #(
    parameter int unsigned W = 8
) (
    input  logic         lb_clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cap
);
    logic [W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = din;
    end

    // Clocked by the returned interface clock, not the core clock.
    always_ff @(posedge lb_clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign cap = cap_q;
endmodule

// File: rtl/lbk_handoff.sv
module lbk_handoff #(
    parameter int unsigned W   = 8,
    parameter int unsigned DIV = 6,
    parameter int unsigned LAT = 3,
    parameter int unsigned CW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] phase,
    input  logic [W-1:0]  cap,
    output logic [W-1:0]  dout,
    output logic          valid
);
    // Phase 0 is held in the cycle after the clock-out rising edge, so a load
    // decided at phase LAT-1 lands on the LAT-th core edge after that edge.
    localparam logic [CW-1:0] LOAD_PH = CW'(LAT - 1);

    typedef struct packed {
        logic [W-1:0] data;
        logic         valid;
    } ho_st_t;

    ho_st_t st_d, st_q;
    logic   load;

    always_comb begin
        load       = (phase == LOAD_PH);
        st_d       = st_q;
        st_d.valid = load;
        if (load) begin
            st_d.data = cap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout  = st_q.data;
    assign valid = st_q.valid;
endmodule

// File: rtl/lbk_bridge.sv
module lbk_bridge #(
    parameter int unsigned W   = lbk_pkg::LBK_W_DEF,
    parameter int unsigned DIV = lbk_pkg::LBK_DIV_DEF,
    parameter int unsigned LAT = lbk_pkg::LBK_LAT_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lb_clk,
    input  logic [W-1:0] lb_data,
    output logic         ifc_clk_out,
    output logic [W-1:0] core_data,
    output logic         core_valid
);
    localparam int unsigned CW = lbk_pkg::lbk_cnt_width(DIV);

    logic [CW-1:0] phase;
    logic [W-1:0]  cap;

    lbk_clkdiv #(.DIV(DIV), .CW(CW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .clk_o (ifc_clk_out)
    );

    lbk_capture #(.W(W)) u_cap (
        .lb_clk (lb_clk),
        .rst_n  (rst_n),
        .din    (lb_data),
        .cap    (cap)
    );

    lbk_handoff #(.W(W), .DIV(DIV), .LAT(LAT), .CW(CW)) u_ho (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .cap   (cap),
        .dout  (core_data),
        .valid (core_valid)
    );
endmodule

// File: rtl/lbk_bridge_chk.sv
module lbk_bridge_chk #(
    parameter int unsigned W   = 8,
    parameter int unsigned DIV = 6,
    parameter int unsigned LAT = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ifc_clk_out,
    input logic [W-1:0] core_data,
    input logic         core_valid
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned AW   = $clog2(DIV + 1) + 1;

    // Independent age counter: cycles since the checker saw clock-out rise.
    logic          prev_q, seen_q, rise;
    logic [AW-1:0] cnt_q, age;

    always_comb begin
        rise = ifc_clk_out && !prev_q;
        age  = rise ? '0 : cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= ifc_clk_out;
            seen_q <= seen_q | rise;
            cnt_q  <= (age == AW'(DIV)) ? age : age + 1'b1;
        end
    end

    assert_clk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ifc_clk_out |-> (age < AW'(HALF)));

    assert_clk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !ifc_clk_out) |-> (age >= AW'(HALF) && age < AW'(DIV)));

    assert_valid_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid |-> (seen_q && age == AW'(LAT)));

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid |=> !core_valid);

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !core_valid |-> $stable(core_data));
endmodule

bind lbk_bridge lbk_bridge_chk #(.W(W), .DIV(DIV), .LAT(LAT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ifc_clk_out (ifc_clk_out),
    .core_data   (core_data),
    .core_valid  (core_valid)
);

// File: tb/sim_lbk_bridge.sv
`timescale 1ns/1ps
module sim_lbk_bridge;
    localparam int W    = 8;
    localparam int DIV  = 6;
    localparam int LAT  = 3;
    localparam int HALF = DIV / 2;

    logic         clk     = 1'b0;
    logic         rst_n   = 1'b0;
    logic         lb_clk  = 1'b0;
    logic [W-1:0] lb_data = '0;
    logic         ifc_clk_out;
    logic [W-1:0] core_data;
    logic         core_valid;

    int dly   = 0;
    int nf    = 0;
    int seed  = 0;
    int n_cmp = 0;
    int n_bad = 0;

    lbk_bridge #(.W(W), .DIV(DIV), .LAT(LAT)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .lb_clk      (lb_clk),
        .lb_data     (lb_data),
        .ifc_clk_out (ifc_clk_out),
        .core_data   (core_data),
        .core_valid  (core_valid)
    );

    always #5 clk = ~clk;

    // Matched external trace: transport delay of dly ns.
    always @(ifc_clk_out) lb_clk <= #(dly) ifc_clk_out;

    function automatic logic [W-1:0] pat(int n, int s);
        return W'(n * 29 + s * 53 + 7);
    endfunction

    // Device model: presents the next word after each falling edge it sees.
    always @(negedge lb_clk) begin
        nf = nf + 1;
        lb_data = pat(nf, seed);
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic check_reset(string req);
        chk(ifc_clk_out == 1'b0, req, int'(ifc_clk_out), 0);
        chk(core_valid == 1'b0, req, int'(core_valid), 0);
        chk(core_data == '0, req, int'(core_data), 0);
    endtask

    task automatic sweep(int d, int s, int periods);
        @(negedge clk);
        #2 rst_n = 1'b0;            // asynchronous, away from any edge
        #1 check_reset("R1 R8 async reset");
        repeat (4) @(negedge clk);
        dly     = d;
        seed    = s;
        nf      = 0;
        lb_data = pat(0, s);
        check_reset("R1 held reset");
        rst_n = 1'b1;
        for (int e = 0; e < periods * DIV; e++) begin
            logic         exp_clk;
            logic         exp_v;
            logic [W-1:0] exp_d;
            @(negedge clk);
            exp_clk = ((e % DIV) < HALF);
            exp_v   = ((e % DIV) == LAT);
            exp_d   = (e < LAT) ? '0 : pat((e - LAT) / DIV, s);
            chk(ifc_clk_out == exp_clk, "R2 R8 clock-out phase", int'(ifc_clk_out), int'(exp_clk));
            chk(core_valid == exp_v, "R4 R6 strobe cycle", int'(core_valid), int'(exp_v));
            chk(core_data == exp_d, "R3 R5 R6 R7 transferred word", int'(core_data), int'(exp_d));
        end
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL R6 watchdog expired: actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset("R1 power-on reset");
        // Delay sweep over the window that stays below LAT core cycles.
        for (int d = 0; d <= 24; d += 3) begin
            sweep(d, d + 1, 8);
        end
        sweep(10, 91, 6);           // returned edge coincides with a core edge
        sweep(20, 17, 6);
        sweep(0, 200, 4);
        summary();
    end
endmodule